// File: doc/BRIEF.md
# Direction-Partitioned Shared Byte FIFO

This block holds the data buffering for one serial peripheral channel. A single 64-byte storage array is shared between the transmit and receive paths, and two enable inputs decide how the array is divided. When only one direction is enabled, that direction gets the whole array as one 64-deep FIFO. When both directions are enabled, the array is divided into two independent 32-deep FIFOs. Transmit uses the lower half and receive uses the upper half. Each of these FIFOs has its own read pointer, write pointer, occupancy count and flags.

Each direction has a push port and a pop port. The word that a pop removes appears on that direction's read-data output in the cycle after the pop. Whenever the enable pair changes, every pointer, count and sticky flag is cleared, so the new arrangement always starts empty. A push to a full FIFO is refused and raises a sticky overflow flag. A pop from an empty FIFO leaves the last read word on the output and raises a sticky underflow flag.

Top module: `shared_dir_fifo`

## Requirements
- R1: With transmit enabled and receive disabled (`tx_en_i`=1, `rx_en_i`=0), the transmit FIFO accepts exactly 64 words. `tx_full_o` rises when `tx_count_o` reaches 64.
- R2: With receive enabled and transmit disabled (`tx_en_i`=0, `rx_en_i`=1), the receive FIFO accepts exactly 64 words. `rx_full_o` rises when `rx_count_o` reaches 64.
- R3: With both directions enabled, each FIFO holds at most 32 words. Each has its own pointers and count, so pushes and pops on one direction never change the other direction's count or data.
- R4: Words leave a FIFO in the order they entered. A pop places the oldest word on `*_rdata_o` in the cycle after the pop.
- R5: A push to a full FIFO is ignored, so the count and the stored contents do not change. It also sets the sticky `*_ovf_o` flag.
- R6: A pop from an empty FIFO leaves `*_rdata_o` at its previous value and sets the sticky `*_udf_o` flag.
- R7: When a push and a pop reach the same FIFO in one cycle, and that FIFO is neither full nor empty, both are carried out and the count stays the same.
- R8: A change of the pair {`tx_en_i`,`rx_en_i`} sets both counts to 0 and clears both overflow and underflow flags one cycle later. Pushes and pops in the cycle of the change are ignored.
- R9: A disabled direction reports count 0 with both its full and empty flags at 1. It ignores pushes and pops and never sets its overflow or underflow flag.
- R10: After reset, both directions are disabled, both counts are 0, both read-data outputs are 0, and all overflow and underflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit FIFO enable |
| rx_en_i | input | 1 | Receive FIFO enable |
| tx_push_i | input | 1 | Write one word into the transmit FIFO |
| tx_wdata_i | input | 8 | Transmit word to write |
| tx_pop_i | input | 1 | Remove one word from the transmit FIFO |
| tx_rdata_o | output | 8 | Last word popped from the transmit FIFO |
| tx_count_o | output | 7 | Transmit occupancy |
| tx_full_o | output | 1 | Transmit FIFO full, or transmit disabled |
| tx_empty_o | output | 1 | Transmit FIFO empty, or transmit disabled |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| tx_udf_o | output | 1 | Sticky transmit underflow |
| rx_push_i | input | 1 | Write one word into the receive FIFO |
| rx_wdata_i | input | 8 | Receive word to write |
| rx_pop_i | input | 1 | Remove one word from the receive FIFO |
| rx_rdata_o | output | 8 | Last word popped from the receive FIFO |
| rx_count_o | output | 7 | Receive occupancy |
| rx_full_o | output | 1 | Receive FIFO full, or receive disabled |
| rx_empty_o | output | 1 | Receive FIFO empty, or receive disabled |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| rx_udf_o | output | 1 | Sticky receive underflow |

## Verification
The following properties are asserted on every cycle:
- the count never exceeds the active depth;
- a refused push leaves the count unchanged and raises the overflow flag;
- a balanced push and pop keeps the count steady;
- a refused pop holds the read data;
- a configuration change empties both FIFOs;
- a disabled direction stays at zero.

Properties over many cycles need the bench's scenarios: first-in-first-out data order across a full 64- or 32-word sweep, the exact depth at which each arrangement fills, and the isolation of the two halves in split mode. The bench checks these by comparing the data popped against arithmetic patterns.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  // configuration pair {tx_en, rx_en}
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_RX    = 2'b01,
    MODE_TX    = 2'b10,
    MODE_SPLIT = 2'b11
  } sdf_mode_e;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [1:0]        we_i,
  input  logic [ADDR_W-1:0] waddr_i [2],
  input  logic [DATA_W-1:0] wdata_i [2],
  input  logic [ADDR_W-1:0] raddr_i [2],
  output logic [DATA_W-1:0] rdata_o [2]
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // the two write ports only both fire in split mode, on disjoint halves
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < 2; p++) begin
      if (we_i[p]) mem_q[waddr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/sdf_ptr_ctrl.sv
module sdf_ptr_ctrl #(
  parameter int ADDR_W = 6,
  localparam int CW = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [CW-1:0]     depth_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [ADDR_W-1:0] rd_ptr_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              udf_o
);
  logic [ADDR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [CW-1:0]     cnt_q;
  logic              ovf_q, udf_q;
  logic              act, at_full, at_empty;

  assign act      = en_i & ~clr_i;
  assign at_full  = (cnt_q == depth_i);
  assign at_empty = (cnt_q == '0);
  assign push_ok_o = act & push_i & ~at_full;
  assign pop_ok_o  = act & pop_i & ~at_empty;

  // pointers wrap at the active depth, not the array size
  always_comb begin
    wr_nxt = ({1'b0, wr_q} == depth_i - CW'(1)) ? '0 : wr_q + ADDR_W'(1);
    rd_nxt = ({1'b0, rd_q} == depth_i - CW'(1)) ? '0 : rd_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (push_ok_o) wr_q <= wr_nxt;
      if (pop_ok_o)  rd_q <= rd_nxt;
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (act && push_i && at_full)  ovf_q <= 1'b1;
      if (act && pop_i && at_empty)  udf_q <= 1'b1;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;
  assign full_o   = ~en_i | at_full;
  assign empty_o  = ~en_i | at_empty;
  assign ovf_o    = ovf_q;
  assign udf_o    = udf_q;

  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= depth_i || clr_i || $past(clr_i));
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && push_i && at_full && !pop_i) |=> (cnt_q == $past(cnt_q) && ovf_q));
  assert_underflow_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && pop_i && at_empty) |=> udf_q);
  assert_balanced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok_o && pop_ok_o) |=> (cnt_q == $past(cnt_q)));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !ovf_q && !udf_q));
endmodule

// File: rtl/shared_dir_fifo.sv
module shared_dir_fifo
  import sdf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int CW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int HALF  = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  output logic [CW-1:0]     tx_count_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic              tx_ovf_o,
  output logic              tx_udf_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic [CW-1:0]     rx_count_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic              rx_ovf_o,
  output logic              rx_udf_o
);
  sdf_mode_e   mode_q;
  logic        cfg_chg;
  logic [1:0]  en, push, pop, push_ok, pop_ok, full, empty, ovf, udf;
  logic [CW-1:0]     depth [2];
  logic [ADDR_W-1:0] base [2];
  logic [ADDR_W-1:0] wr_ptr [2], rd_ptr [2];
  logic [ADDR_W-1:0] waddr [2], raddr [2];
  logic [DATA_W-1:0] wdata [2], mem_rd [2];
  logic [CW-1:0]     count [2];
  logic [DATA_W-1:0] rdata_q [2];

  assign cfg_chg = ({tx_en_i, rx_en_i} != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= sdf_mode_e'({tx_en_i, rx_en_i});
  end

  assign en[DIR_TX]    = mode_q[1];
  assign en[DIR_RX]    = mode_q[0];
  assign push          = {rx_push_i, tx_push_i};
  assign pop           = {rx_pop_i, tx_pop_i};
  assign wdata[DIR_TX] = tx_wdata_i;
  assign wdata[DIR_RX] = rx_wdata_i;

  // split: tx owns the lower half, rx the upper half
  always_comb begin
    depth[DIR_TX] = (mode_q == MODE_SPLIT) ? CW'(HALF) : CW'(DEPTH);
    depth[DIR_RX] = depth[DIR_TX];
    base[DIR_TX]  = '0;
    base[DIR_RX]  = (mode_q == MODE_SPLIT) ? ADDR_W'(HALF) : '0;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    sdf_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[d]),
      .clr_i     (cfg_chg),
      .depth_i   (depth[d]),
      .push_i    (push[d]),
      .pop_i     (pop[d]),
      .push_ok_o (push_ok[d]),
      .pop_ok_o  (pop_ok[d]),
      .wr_ptr_o  (wr_ptr[d]),
      .rd_ptr_o  (rd_ptr[d]),
      .count_o   (count[d]),
      .full_o    (full[d]),
      .empty_o   (empty[d]),
      .ovf_o     (ovf[d]),
      .udf_o     (udf[d])
    );

    assign waddr[d] = base[d] + wr_ptr[d];
    assign raddr[d] = base[d] + rd_ptr[d];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q[d] <= '0;
      else if (pop_ok[d]) rdata_q[d] <= mem_rd[d];
    end

    assert_hold_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop[d] && !pop_ok[d]) |=> $stable(rdata_q[d]));
    assert_disabled_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en[d] && !cfg_chg) |=> (count[d] == '0 && !ovf[d] && !udf[d]));
  end

  sdf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (mem_rd)
  );

  assign tx_rdata_o = rdata_q[DIR_TX];
  assign tx_count_o = count[DIR_TX];
  assign tx_full_o  = full[DIR_TX];
  assign tx_empty_o = empty[DIR_TX];
  assign tx_ovf_o   = ovf[DIR_TX];
  assign tx_udf_o   = udf[DIR_TX];
  assign rx_rdata_o = rdata_q[DIR_RX];
  assign rx_count_o = count[DIR_RX];
  assign rx_full_o  = full[DIR_RX];
  assign rx_empty_o = empty[DIR_RX];
  assign rx_ovf_o   = ovf[DIR_RX];
  assign rx_udf_o   = udf[DIR_RX];

  assert_split_depth_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SPLIT && !$past(cfg_chg)) |->
      (count[DIR_TX] <= CW'(HALF) && count[DIR_RX] <= CW'(HALF)));
endmodule

// File: tb/shared_dir_fifo_bench.sv
module shared_dir_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic [1:0] push = '0, pop = '0;
  logic [7:0] wd [2];
  logic [7:0] tx_rd, rx_rd;
  logic [6:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, tx_ovf, tx_udf, rx_full, rx_empty, rx_ovf, rx_udf;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  shared_dir_fifo u_shared_dir_fifo (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_push_i(push[0]), .tx_wdata_i(wd[0]), .tx_pop_i(pop[0]), .tx_rdata_o(tx_rd),
    .tx_count_o(tx_cnt), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .tx_ovf_o(tx_ovf), .tx_udf_o(tx_udf),
    .rx_push_i(push[1]), .rx_wdata_i(wd[1]), .rx_pop_i(pop[1]), .rx_rdata_o(rx_rd),
    .rx_count_o(rx_cnt), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .rx_ovf_o(rx_ovf), .rx_udf_o(rx_udf)
  );

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((i * (2 * seed + 7) + 31 * seed + 5) & 255);
  endfunction

  function automatic int cnt(int d);
    return (d == 0) ? int'(tx_cnt) : int'(rx_cnt);
  endfunction
  function automatic int rd(int d);
    return (d == 0) ? int'(tx_rd) : int'(rx_rd);
  endfunction
  function automatic int fl(int d);
    return (d == 0) ? {tx_full, tx_empty, tx_ovf, tx_udf} : {rx_full, rx_empty, rx_ovf, rx_udf};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic t, input logic r);
    tx_en = t; rx_en = r;
    step();
    step();
  endtask

  task automatic do_push(input int d, input logic [7:0] v);
    push[d] = 1'b1; wd[d] = v;
    step();
    push[d] = 1'b0;
  endtask

  task automatic do_pop(input int d);
    pop[d] = 1'b1;
    step();
    pop[d] = 1'b0;
  endtask

  // fill to depth, overflow, drain in order, underflow
  task automatic sweep(input int d, input int depth, input int seed, input string tag);
    for (int i = 0; i < depth; i++) begin
      do_push(d, pat(seed, i));
      chk({tag, " count"}, cnt(d), i + 1);
    end
    chk({tag, " full flag"}, fl(d) >> 3, 1);
    do_push(d, 8'hEE);
    chk("R5 count after refused push", cnt(d), depth);
    chk("R5 overflow flag", (fl(d) >> 1) & 1, 1);
    for (int i = 0; i < depth; i++) begin
      do_pop(d);
      chk("R4 order", rd(d), int'(pat(seed, i)));
    end
    chk({tag, " empty flag"}, (fl(d) >> 2) & 1, 1);
    do_pop(d);
    chk("R6 underflow flag", fl(d) & 1, 1);
    chk("R6 data held", rd(d), int'(pat(seed, depth - 1)));
  endtask

  task automatic balanced(input int d, input int seed);
    for (int i = 0; i < 5; i++) do_push(d, pat(seed, i));
    for (int i = 0; i < 10; i++) begin
      push[d] = 1'b1; wd[d] = pat(seed, i + 5); pop[d] = 1'b1;
      step();
      push[d] = 1'b0; pop[d] = 1'b0;
      chk("R7 count steady", cnt(d), 5);
      chk("R7 data order", rd(d), int'(pat(seed, i)));
    end
  endtask

  initial begin
    wd[0] = '0; wd[1] = '0;
    #55 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 tx count", int'(tx_cnt), 0);
    chk("R10 rx count", int'(rx_cnt), 0);
    chk("R10 tx flags", fl(0), 4'b1100);
    chk("R10 rx flags", fl(1), 4'b1100);
    chk("R10 rdata", int'(tx_rd) + int'(rx_rd), 0);

    // transmit only
    set_cfg(1'b1, 1'b0);
    sweep(0, 64, 1, "R1");
    do_push(1, 8'h55);
    do_pop(1);
    chk("R9 rx ignored count", int'(rx_cnt), 0);
    chk("R9 rx flags", fl(1), 4'b1100);
    chk("R9 rx rdata", int'(rx_rd), 0);

    // receive only, change clears everything
    set_cfg(1'b0, 1'b1);
    chk("R8 tx cleared", int'(tx_cnt), 0);
    chk("R8 tx flags cleared", fl(0), 4'b1100);
    sweep(1, 64, 2, "R2");
    balanced(1, 3);

    // split mode
    set_cfg(1'b1, 1'b1);
    chk("R8 rx cleared", int'(rx_cnt), 0);
    chk("R8 rx flags cleared", fl(1), 4'b0100);
    for (int i = 0; i < 10; i++) do_push(0, pat(4, i));
    sweep(1, 32, 5, "R3");
    chk("R3 tx count untouched", int'(tx_cnt), 10);
    for (int i = 0; i < 10; i++) begin
      do_pop(0);
      chk("R3 tx data isolated", int'(tx_rd), int'(pat(4, i)));
    end
    chk("R3 rx count untouched", int'(rx_cnt), 0);
    set_cfg(1'b0, 1'b0);
    set_cfg(1'b1, 1'b1);
    sweep(0, 32, 6, "R3");
    balanced(0, 7);

    // change mid-fill, with a push in the change cycle
    for (int i = 0; i < 7; i++) do_push(1, pat(8, i));
    rx_en = 1'b0;
    push[1] = 1'b1; push[0] = 1'b1; wd[0] = 8'h11;
    step();
    push = '0;
    chk("R8 push ignored at change", int'(tx_cnt), 0);
    chk("R8 rx count after change", int'(rx_cnt), 0);
    step();
    sweep(0, 64, 9, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule